// File: doc/BRIEF.md
# Transmit Payload Store With Repeat Mode

This block stores outgoing radio packets between the command decoder that fills them and the transmitter that drains them. A packet is opened with a start strobe, filled one byte per byte strobe from position zero upward, and closed with an end strobe. The transmitter asks for a packet with a one-cycle request. The block then streams that packet's bytes on consecutive cycles, with the packet length alongside and a marker on the final byte.

Three packet slots are kept in first-in, first-out order. A flush discards everything. In the repeat mode, the packet sent most recently is not released. Every request made while the chip-enable line is high sends that packet again, until a new packet write or a flush ends the mode. The mode cannot be switched on while a packet is streaming out.

Top module: `txpl_buffer`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `overflow`, `tx_valid` and `reuse_active` are 0.
- R2: A request sampled high at clock edge k sends the oldest packet. Its bytes are valid after edges k+1 through k+len, in written order starting with byte position 0. `tx_len` holds len for every byte, and `tx_last` is 1 only on the final byte.
- R3: Up to three packets are kept and sent in the order written. `full` is 1 when three packets are held and `empty` is 1 when none is held. A packet sent in normal mode frees its slot.
- R4: A start strobe while `full` is 1 stores nothing and leaves the stored packets unchanged. It raises `overflow` for exactly one cycle.
- R5: Byte strobes beyond the 32nd of a packet are dropped, so the packet is stored with length 32. A packet closed with no bytes is discarded.
- R6: A flush empties the store, discards a packet being written, stops a packet being sent (`tx_valid` is 0 from the next cycle), and turns the repeat mode off.
- R7: A repeat request made while idle, after at least one packet has been sent, sets `reuse_active`. After that, each request sends the last sent packet again and leaves `empty` and `full` unchanged.
- R8: An accepted start strobe or a flush clears `reuse_active`, and the next request sends the next queued packet.
- R9: A repeat request is ignored while a packet is being sent, and also when no packet has been sent since reset, flush or the last write.
- R10: A send request is ignored when `ce` is 0, when a packet is already being sent, or when no packet is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; send requests are taken only while high |
| wr_start | input | 1 | Opens a new packet at byte position 0 |
| wr_byte | input | 1 | Stores `wr_data` at the next byte position |
| wr_end | input | 1 | Closes the open packet and queues it |
| wr_data | input | 8 | Byte to store |
| flush | input | 1 | Discards all stored packets |
| reuse_req | input | 1 | Asks for the repeat mode |
| tx_req | input | 1 | Asks for one packet |
| tx_valid | output | 1 | `tx_data` carries a packet byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_len | output | 6 | Length of the packet being sent |
| full | output | 1 | All three slots occupied |
| empty | output | 1 | No slot occupied |
| overflow | output | 1 | One-cycle pulse: a write was refused |
| reuse_active | output | 1 | Repeat mode on |

## Verification
The assertions assume that `wr_start`, `wr_byte` and `wr_end` never rise together, and that no packet write is opened while a repeated packet is streaming out. A write opened then could land in the slot being read. The directed stimulus drives one control strobe per cycle and starts writes only while the sender is idle. It does raise send and repeat requests during a transmission, because those cases must be ignored.

// File: rtl/txpl_pkg.sv
package txpl_pkg;
  localparam int unsigned TXPL_SLOTS_DEF  = 3;
  localparam int unsigned TXPL_BYTES_DEF  = 32;
  localparam int unsigned TXPL_DATA_W_DEF = 8;
endpackage

// File: rtl/txpl_ram.sv
module txpl_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 96,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txpl_writer.sv
module txpl_writer #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MAX_BYTES = 32,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned LEN_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_start,
  input  logic              wr_byte,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              full,
  input  logic [SLOT_W-1:0] slot,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              start_ok,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic              overflow
);
  logic             open_q;
  logic [LEN_W-1:0] idx_q;

  assign start_ok   = wr_start && !full && !flush;
  assign mem_we     = open_q && wr_byte && !wr_start && !wr_end && !flush
                      && (idx_q < LEN_W'(MAX_BYTES));
  assign mem_waddr  = ADDR_W'(slot) * ADDR_W'(MAX_BYTES) + ADDR_W'(idx_q);
  assign mem_wdata  = wr_data;
  assign commit     = open_q && wr_end && !wr_start && !flush && (idx_q != '0);
  assign commit_len = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      idx_q    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= wr_start && full && !flush;
      if (flush) begin
        open_q <= 1'b0;
        idx_q  <= '0;
      end else if (start_ok) begin
        open_q <= 1'b1;
        idx_q  <= '0;
      end else if (open_q && wr_end) begin
        open_q <= 1'b0;
      end else if (mem_we) begin
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end

  // a refused write never leaves a packet open
  assert_overflow_closed_R4: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !open_q);
  // the byte position never passes the slot size
  assert_idx_cap_R5: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LEN_W'(MAX_BYTES));
endmodule

// File: rtl/txpl_reader.sv
module txpl_reader #(
  parameter int unsigned MAX_BYTES = 32,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned LEN_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] raddr,
  output logic              tx_valid,
  output logic              tx_last,
  output logic [LEN_W-1:0]  tx_len
);
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;

  assign done   = busy && !flush && (idx_q == len_q - LEN_W'(1));
  assign raddr  = ADDR_W'(slot_q) * ADDR_W'(MAX_BYTES) + ADDR_W'(idx_q);
  assign tx_len = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      idx_q    <= '0;
      slot_q   <= '0;
      len_q    <= '0;
    end else if (flush) begin
      busy     <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      tx_valid <= busy;
      tx_last  <= done;
      if (busy) idx_q <= idx_q + LEN_W'(1);
      if (done) busy <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        idx_q  <= '0;
        slot_q <= start_slot;
        len_q  <= start_len;
      end
    end
  end

  // a packet's final byte is always followed by an idle cycle
  assert_last_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !tx_valid);
  // every sent byte carries a legal length
  assert_len_range_R2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(MAX_BYTES)));
endmodule

// File: rtl/txpl_buffer.sv
module txpl_buffer
  import txpl_pkg::*;
#(
  parameter int unsigned SLOTS     = TXPL_SLOTS_DEF,
  parameter int unsigned MAX_BYTES = TXPL_BYTES_DEF,
  parameter int unsigned DATA_W    = TXPL_DATA_W_DEF,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              wr_start,
  input  logic              wr_byte,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic              reuse_req,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic [LEN_W-1:0]  tx_len,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              reuse_active
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned DEPTH  = SLOTS * MAX_BYTES;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [SLOT_W-1:0] wr_ptr, rd_ptr, last_slot, cur_slot;
  logic [CNT_W-1:0]  count;
  logic              reuse_on, last_valid, keep_cur;
  logic [LEN_W-1:0]  len_tab [SLOTS];

  logic              mem_we, start_ok, commit, busy, done, tx_accept, pop;
  logic [ADDR_W-1:0] mem_waddr, raddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [LEN_W-1:0]  commit_len, start_len;
  logic [SLOT_W-1:0] start_slot;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(SLOTS - 1)) ? '0 : p + SLOT_W'(1);
  endfunction

  assign full         = (count == CNT_W'(SLOTS));
  assign empty        = (count == '0);
  assign reuse_active = reuse_on;
  assign start_slot   = reuse_on ? last_slot : rd_ptr;
  assign start_len    = len_tab[start_slot];
  assign tx_accept    = tx_req && ce && !busy && !flush && (reuse_on || !empty);
  assign pop          = done && !keep_cur;

  txpl_writer #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .SLOT_W(SLOT_W),
                .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_writer (
    .clk(clk), .rst(rst), .flush(flush), .wr_start(wr_start), .wr_byte(wr_byte),
    .wr_end(wr_end), .wr_data(wr_data), .full(full), .slot(wr_ptr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .start_ok(start_ok), .commit(commit), .commit_len(commit_len),
    .overflow(overflow));

  txpl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(tx_data));

  txpl_reader #(.MAX_BYTES(MAX_BYTES), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
                .LEN_W(LEN_W)) u_reader (
    .clk(clk), .rst(rst), .flush(flush), .start(tx_accept),
    .start_slot(start_slot), .start_len(start_len), .busy(busy), .done(done),
    .raddr(raddr), .tx_valid(tx_valid), .tx_last(tx_last), .tx_len(tx_len));

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (rst) len_tab[s] <= '0;
      else if (commit && wr_ptr == SLOT_W'(s)) len_tab[s] <= commit_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      reuse_on   <= 1'b0;
      last_valid <= 1'b0;
      last_slot  <= '0;
      keep_cur   <= 1'b0;
      cur_slot   <= '0;
    end else begin
      unique case ({commit, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
      if (commit) wr_ptr <= nxt(wr_ptr);
      if (pop) begin
        rd_ptr     <= nxt(rd_ptr);
        last_slot  <= cur_slot;
        last_valid <= 1'b1;
      end
      if (start_ok) begin
        reuse_on   <= 1'b0;
        last_valid <= 1'b0;
      end else if (reuse_req && !busy && last_valid) begin
        reuse_on <= 1'b1;
      end
      if (tx_accept) begin
        keep_cur <= reuse_on;
        cur_slot <= start_slot;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(SLOTS));
  assert_flag_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // the repeat mode does not switch on while a packet is going out
  assert_reuse_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !flush && !start_ok) |=> $stable(reuse_on));
  // a repeated packet keeps its place in the occupancy
  assert_keep_count_R7: assert property (@(posedge clk) disable iff (rst)
    (done && keep_cur && !flush && !commit) |=> $stable(count));
  assert_flush_clear_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !reuse_active && !tx_valid));
endmodule

// File: tb/txpl_buffer_test.sv
module txpl_buffer_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, ce, wr_start, wr_byte, wr_end, flush, reuse_req, tx_req;
  logic [7:0] wr_data;
  logic       tx_valid, tx_last, full, empty, overflow, reuse_active;
  logic [7:0] tx_data;
  logic [5:0] tx_len;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  txpl_buffer uut (
    .clk(clk), .rst(rst), .ce(ce), .wr_start(wr_start), .wr_byte(wr_byte),
    .wr_end(wr_end), .wr_data(wr_data), .flush(flush), .reuse_req(reuse_req),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_len(tx_len), .full(full), .empty(empty), .overflow(overflow),
    .reuse_active(reuse_active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_pkt(input int n, input int base);
    @(negedge clk) wr_start = 1'b1;
    @(negedge clk) wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      wr_byte = 1'b1;
      wr_data = 8'(base + i);
      @(negedge clk);
    end
    wr_byte = 1'b0;
    wr_end  = 1'b1;
    @(negedge clk) wr_end = 1'b0;
  endtask

  task automatic tx_begin(input bit again, input bit rpt);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) begin tx_req = again; reuse_req = rpt; end
  endtask

  task automatic collect(input int len, input int base, input string req);
    int got = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      tx_req = 1'b0;
      reuse_req = 1'b0;
      if (tx_valid) begin
        chk(tx_data == 8'(base + got), req, tx_data, 8'(base + got));
        chk(tx_len == 6'(len), req, tx_len, len);
        chk(tx_last == (got == len - 1), req, tx_last, got == len - 1);
        got++;
        if (tx_last) break;
      end
    end
    chk(got == len, req, got, len);
  endtask

  task automatic send(input int len, input int base, input string req);
    tx_begin(1'b0, 1'b0);
    collect(len, base, req);
  endtask

  task automatic pulse_flush;
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
  endtask

  task automatic pulse_reuse;
    @(negedge clk) reuse_req = 1'b1;
    @(negedge clk) reuse_req = 1'b0;
  endtask

  task automatic idle_no_valid(input int cyc, input string req);
    int seen = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      tx_req = 1'b0;
      if (tx_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(reuse_active == 1'b0, "R1 reuse", reuse_active, 0);
  endtask

  task automatic t_basic;
    wr_pkt(5, 8'h40);
    chk(empty == 1'b0, "R3 not empty", empty, 0);
    send(5, 8'h40, "R2 basic");
    chk(empty == 1'b1, "R3 freed", empty, 1);
  endtask

  task automatic t_order_and_overflow;
    wr_pkt(1, 8'h10);
    wr_pkt(7, 8'h20);
    wr_pkt(3, 8'h30);
    chk(full == 1'b1, "R3 full", full, 1);
    @(negedge clk) wr_start = 1'b1;
    @(negedge clk) wr_start = 1'b0;
    chk(overflow == 1'b1, "R4 pulse", overflow, 1);
    wr_byte = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    chk(overflow == 1'b0, "R4 one cycle", overflow, 0);
    wr_byte = 1'b0; wr_end = 1'b1;
    @(negedge clk) wr_end = 1'b0;
    chk(full == 1'b1, "R4 still full", full, 1);
    send(1, 8'h10, "R3 order first");
    chk(full == 1'b0, "R3 not full", full, 0);
    send(7, 8'h20, "R4 contents kept");
    send(3, 8'h30, "R3 order third");
    chk(empty == 1'b1, "R3 empty", empty, 1);
  endtask

  task automatic t_limits;
    wr_pkt(34, 8'h80);
    send(32, 8'h80, "R5 capped");
    wr_pkt(0, 8'h00);
    chk(empty == 1'b1, "R5 zero length", empty, 1);
  endtask

  task automatic t_ignored_requests;
    tx_begin(1'b0, 1'b0);
    idle_no_valid(4, "R10 nothing queued");
    wr_pkt(4, 8'h50);
    wr_pkt(2, 8'h60);
    ce = 1'b0;
    tx_begin(1'b0, 1'b0);
    idle_no_valid(4, "R10 ce low");
    ce = 1'b1;
    tx_begin(1'b1, 1'b0);
    collect(4, 8'h50, "R10 busy first");
    idle_no_valid(4, "R10 busy request");
    chk(empty == 1'b0, "R10 second kept", empty, 0);
    send(2, 8'h60, "R10 second");
  endtask

  task automatic t_reuse;
    wr_pkt(4, 8'hA0);
    send(4, 8'hA0, "R7 first send");
    pulse_reuse();
    chk(reuse_active == 1'b1, "R7 active", reuse_active, 1);
    send(4, 8'hA0, "R7 repeat one");
    send(4, 8'hA0, "R7 repeat two");
    chk(empty == 1'b1, "R7 occupancy", empty, 1);
    wr_pkt(2, 8'hB0);
    chk(reuse_active == 1'b0, "R8 write clears", reuse_active, 0);
    send(2, 8'hB0, "R8 next packet");
  endtask

  task automatic t_reuse_busy;
    wr_pkt(30, 8'hC0);
    tx_begin(1'b0, 1'b1);
    collect(30, 8'hC0, "R9 send");
    chk(reuse_active == 1'b0, "R9 busy ignored", reuse_active, 0);
    pulse_reuse();
    chk(reuse_active == 1'b1, "R9 idle accepted", reuse_active, 1);
    send(30, 8'hC0, "R7 repeat long");
    pulse_flush();
    chk(reuse_active == 1'b0, "R8 flush clears", reuse_active, 0);
    pulse_reuse();
    chk(reuse_active == 1'b0, "R9 nothing sent", reuse_active, 0);
  endtask

  task automatic t_flush;
    wr_pkt(3, 8'h11);
    wr_pkt(3, 8'h22);
    pulse_flush();
    chk(empty == 1'b1, "R6 empty", empty, 1);
    chk(full == 1'b0, "R6 not full", full, 0);
    wr_pkt(20, 8'h33);
    tx_begin(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    chk(tx_valid == 1'b0, "R6 abort", tx_valid, 0);
    idle_no_valid(4, "R6 stays idle");
    chk(empty == 1'b1, "R6 empty after abort", empty, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ce = 1'b1; wr_start = 1'b0; wr_byte = 1'b0; wr_end = 1'b0;
    wr_data = 8'h00; flush = 1'b0; reuse_req = 1'b0; tx_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order_and_overflow();
    t_limits();
    t_ignored_requests();
    t_reuse();
    t_reuse_busy();
    t_flush();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule